// File: doc/BRIEF.md
# Compressed ISA Next-PC Unit

This block works out the address of the next instruction for the control-transfer instructions of a 16-bit compressed RISC instruction set. For each accepted instruction it takes the current PC, a decoded control kind, the raw immediate, one register operand, the T8 register and the return-address register. From these it gives the next fetch address, a link value with its write enable, the active ISA mode and a delay-slot flag. Conditional and unconditional PC-relative branches redirect at once. Jumps take effect only after one following instruction, the delay slot, has been accepted.

While the delay-slot instruction runs, the unit holds the captured target and the PC of the jump. Any exception raised by that instruction can then be reported against the jump instead of the slot. Bit 0 of a jump target is not part of the address. It picks the ISA mode that applies once the redirect happens: 1 keeps compressed mode and 0 selects the 32-bit ISA. A control-transfer instruction found in a delay slot is flagged as illegal and has no effect.

Top module: `npc_unit`

## Requirements
- R1: After reset `dslot_o` is 0, `isa16_o` is 1, and with `acc_i` low both `link_we_o` and `illegal_o` are 0.
- R2: `kind_i` encodes 0 none, 1 beqz, 2 bnez, 3 bteqz, 4 btnez, 5 b, 6 jal, 7 jalx, 8 jr, 9 jrra, 10 jalr. The next-instruction address NIA is `pc_i`+4 for jal, jalx or any instruction with `ext_i`=1, and `pc_i`+2 otherwise. Outside a delay slot, a kind-0 instruction gives `npc_o` = NIA.
- R3: beqz and bnez test `reg_i` against zero, and bteqz and btnez test `t8_i` against zero. When taken, `npc_o` = NIA + (sign-extended offset << 1). When not taken, `npc_o` = NIA.
- R4: The offset is `imm_i[7:0]` for a non-extended conditional branch, `imm_i[10:0]` for a non-extended b, and `imm_i[15:0]` for any extended branch. Higher `imm_i` bits are ignored.
- R5: jal and jalx use the 26-bit immediate {`imm_i[20:16]`,`imm_i[25:21]`,`imm_i[15:0]`}, where `imm_i[25:16]` carries bits 9:0 of the first halfword. The target is NIA[31:28] followed by that immediate shifted left by 2.
- R6: The mode bit of the target is 1 for jal, 0 for jalx, and bit 0 of the register value for jr, jrra and jalr. `isa16_o` takes that bit only when the delay-slot instruction is accepted.
- R7: jal, jalx and jalr outside a delay slot raise `link_we_o` with `link_o` = NIA+2. No other instruction raises `link_we_o`.
- R8: An accepted jump gives `npc_o` = NIA and raises `dslot_o` for the next accepted instruction. That instruction gets `npc_o` = target with bit 0 cleared, after which `dslot_o` falls.
- R9: While `acc_i` is low, `dslot_o`, `isa16_o` and any pending target stay unchanged.
- R10: `exc_pc_o` equals the stored jump PC while `dslot_o` is high, and equals `pc_i` otherwise.
- R11: A branch or jump accepted in a delay slot raises `illegal_o`, raises no link, and leaves `npc_o` at the pending target.
- R12: jr and jalr jump to `reg_i`, and jrra jumps to `ra_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 1 | Instruction accepted this cycle |
| pc_i | input | XLEN | PC of the presented instruction |
| kind_i | input | 4 | Decoded control kind |
| ext_i | input | 1 | Instruction is the extended (two-halfword) form |
| imm_i | input | 26 | Raw immediate bits |
| reg_i | input | XLEN | Register operand value |
| t8_i | input | XLEN | T8 register value |
| ra_i | input | XLEN | Return-address register value |
| npc_o | output | XLEN | Next fetch address |
| link_o | output | XLEN | Link value |
| link_we_o | output | 1 | Link write enable |
| isa16_o | output | 1 | 1 = compressed ISA active |
| dslot_o | output | 1 | Presented instruction sits in a delay slot |
| illegal_o | output | 1 | Control transfer found in a delay slot |
| exc_pc_o | output | XLEN | PC to report for an exception |

## Verification
The checker assumes that `kind_i` holds only codes 0 to 10. It also assumes that `ext_i` is set only for kinds that have an extended form, and that `pc_i` is halfword aligned. The stimulus draws every instruction from those legal codes. It aligns all PCs and picks base addresses far from the ends of the address space, so that NIA and branch targets never wrap. Idle cycles with `acc_i` low are placed between a jump and its slot, which exercises the hold behaviour without breaking these assumptions.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        CF_NONE  = 4'd0,
        CF_BEQZ  = 4'd1,
        CF_BNEZ  = 4'd2,
        CF_BTEQZ = 4'd3,
        CF_BTNEZ = 4'd4,
        CF_B     = 4'd5,
        CF_JAL   = 4'd6,
        CF_JALX  = 4'd7,
        CF_JR    = 4'd8,
        CF_JRRA  = 4'd9,
        CF_JALR  = 4'd10
    } cf_kind_e;

    localparam int IMM_W     = 26;
    localparam int SHORT_W   = 8;
    localparam int UNCOND_W  = 11;
    localparam int EXT_W     = 16;
    localparam int REGION_LO = 28;

    function automatic logic is_branch(cf_kind_e k);
        return (k == CF_BEQZ) || (k == CF_BNEZ) || (k == CF_BTEQZ) ||
               (k == CF_BTNEZ) || (k == CF_B);
    endfunction

    function automatic logic is_jump(cf_kind_e k);
        return (k == CF_JAL) || (k == CF_JALX) || (k == CF_JR) ||
               (k == CF_JRRA) || (k == CF_JALR);
    endfunction

    function automatic logic is_link(cf_kind_e k);
        return (k == CF_JAL) || (k == CF_JALX) || (k == CF_JALR);
    endfunction

endpackage

// File: rtl/npc_sext.sv
module npc_sext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);
    generate
        if (IN_W >= OUT_W) begin : g_trunc
            assign val_o = val_i[OUT_W-1:0];
        end else begin : g_ext
            assign val_o = {{(OUT_W-IN_W){val_i[IN_W-1]}}, val_i};
        end
    endgenerate
endmodule

// File: rtl/npc_branch_eval.sv
module npc_branch_eval
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cf_kind_e          kind_i,
    input  logic              ext_i,
    input  logic [EXT_W-1:0]  imm_i,
    input  logic [XLEN-1:0]   reg_i,
    input  logic [XLEN-1:0]   t8_i,
    input  logic [XLEN-1:0]   nia_i,
    output logic              taken_o,
    output logic [XLEN-1:0]   target_o
);
    localparam int NUM_W = 3;
    localparam int OFF_W [NUM_W] = '{SHORT_W, UNCOND_W, EXT_W};

    logic [XLEN-1:0] sx [NUM_W];

    for (genvar g = 0; g < NUM_W; g++) begin : g_off
        npc_sext #(.IN_W(OFF_W[g]), .OUT_W(XLEN)) u_sext (
            .val_i (imm_i[OFF_W[g]-1:0]),
            .val_o (sx[g])
        );
    end

    logic            reg_zero, t8_zero;
    logic [XLEN-1:0] off;

    always_comb begin
        reg_zero = (reg_i == '0);
        t8_zero  = (t8_i == '0);
        unique case (kind_i)
            CF_BEQZ:  taken_o = reg_zero;
            CF_BNEZ:  taken_o = !reg_zero;
            CF_BTEQZ: taken_o = t8_zero;
            CF_BTNEZ: taken_o = !t8_zero;
            CF_B:     taken_o = 1'b1;
            default:  taken_o = 1'b0;
        endcase
        if (ext_i)               off = sx[2];
        else if (kind_i == CF_B) off = sx[1];
        else                     off = sx[0];
        target_o = nia_i + (off << 1);
    end
endmodule

// File: rtl/npc_jump_target.sv
module npc_jump_target
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cf_kind_e         kind_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [XLEN-1:0]  reg_i,
    input  logic [XLEN-1:0]  ra_i,
    input  logic [XLEN-1:0]  nia_i,
    output logic [XLEN-1:0]  target_o
);
    localparam int FIELD_W = 5;
    localparam int LOW_W   = 16;

    logic [IMM_W-1:0]     idx;
    logic [XLEN-1:0]      region;
    logic [REGION_LO-1:0] unused_nia_lo;

    always_comb begin
        // first halfword carries index[20:16] in its upper field, [25:21] in its lower
        idx = {imm_i[LOW_W+FIELD_W-1:LOW_W],
               imm_i[LOW_W+2*FIELD_W-1:LOW_W+FIELD_W],
               imm_i[LOW_W-1:0]};
        region = {nia_i[XLEN-1:REGION_LO], REGION_LO'({idx, 2'b00})};
        unused_nia_lo = nia_i[REGION_LO-1:0];
        unique case (kind_i)
            CF_JAL:  target_o = region | XLEN'(1);
            CF_JALX: target_o = region;
            CF_JRRA: target_o = ra_i;
            default: target_o = reg_i;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [3:0]       kind_i,
    input  logic             ext_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [XLEN-1:0]  reg_i,
    input  logic [XLEN-1:0]  t8_i,
    input  logic [XLEN-1:0]  ra_i,
    output logic [XLEN-1:0]  npc_o,
    output logic [XLEN-1:0]  link_o,
    output logic             link_we_o,
    output logic             isa16_o,
    output logic             dslot_o,
    output logic             illegal_o,
    output logic [XLEN-1:0]  exc_pc_o
);
    typedef struct packed {
        logic            dslot;
        logic            mode;
        logic [XLEN-1:0] pend;
        logic [XLEN-1:0] jpc;
    } npc_state_t;

    npc_state_t st_d, st_q;

    cf_kind_e        kind;
    logic [XLEN-1:0] nia;
    logic            br_taken;
    logic [XLEN-1:0] br_tgt, jmp_tgt;
    logic            wide;

    always_comb begin
        kind = cf_kind_e'(kind_i);
        wide = ext_i || (kind == CF_JAL) || (kind == CF_JALX);
        nia  = pc_i + (wide ? XLEN'(4) : XLEN'(2));
    end

    npc_branch_eval #(.XLEN(XLEN)) u_br (
        .kind_i   (kind),
        .ext_i    (ext_i),
        .imm_i    (imm_i[EXT_W-1:0]),
        .reg_i    (reg_i),
        .t8_i     (t8_i),
        .nia_i    (nia),
        .taken_o  (br_taken),
        .target_o (br_tgt)
    );

    npc_jump_target #(.XLEN(XLEN)) u_jt (
        .kind_i   (kind),
        .imm_i    (imm_i),
        .reg_i    (reg_i),
        .ra_i     (ra_i),
        .nia_i    (nia),
        .target_o (jmp_tgt)
    );

    always_comb begin
        st_d      = st_q;
        npc_o     = nia;
        link_we_o = 1'b0;
        illegal_o = 1'b0;
        link_o    = nia + XLEN'(2);
        exc_pc_o  = st_q.dslot ? st_q.jpc : pc_i;
        if (st_q.dslot) begin
            npc_o = {st_q.pend[XLEN-1:1], 1'b0};
        end else if (br_taken) begin
            npc_o = br_tgt;
        end
        if (acc_i) begin
            if (st_q.dslot) begin
                illegal_o = is_branch(kind) || is_jump(kind);
                st_d.mode  = st_q.pend[0];
                st_d.dslot = 1'b0;
            end else if (is_jump(kind)) begin
                link_we_o  = is_link(kind);
                st_d.dslot = 1'b1;
                st_d.pend  = jmp_tgt;
                st_d.jpc   = pc_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{dslot: 1'b0, mode: 1'b1, pend: '0, jpc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign isa16_o = st_q.mode;
    assign dslot_o = st_q.dslot;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_i,
    input logic [XLEN-1:0] pc_i,
    input logic [3:0]      kind_i,
    input logic            ext_i,
    input logic [XLEN-1:0] npc_o,
    input logic            link_we_o,
    input logic            isa16_o,
    input logic            dslot_o,
    input logic            illegal_o,
    input logic [XLEN-1:0] exc_pc_o
);
    // R2
    seq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !dslot_o && kind_i == 4'd0 && !ext_i) |-> (npc_o == pc_i + XLEN'(2)));

    // R8
    jump_opens_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !dslot_o && kind_i >= 4'd6 && kind_i <= 4'd10) |=> dslot_o);

    // R8
    slot_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && dslot_o) |=> !dslot_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_i |=> ($stable(dslot_o) && $stable(isa16_o)));

    // R6
    mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(isa16_o) |-> $past(acc_i && dslot_o));

    // R7
    link_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (acc_i && !dslot_o));

    // R11
    illegal_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (acc_i && dslot_o && !link_we_o));

    // R10
    exc_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dslot_o |-> (exc_pc_o == pc_i));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_i     (acc_i),
    .pc_i      (pc_i),
    .kind_i    (kind_i),
    .ext_i     (ext_i),
    .npc_o     (npc_o),
    .link_we_o (link_we_o),
    .isa16_o   (isa16_o),
    .dslot_o   (dslot_o),
    .illegal_o (illegal_o),
    .exc_pc_o  (exc_pc_o)
);

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
    import npc_pkg::*;

    localparam int XLEN = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_i = 1'b0;
    logic [XLEN-1:0]  pc_i = '0;
    logic [3:0]       kind_i = '0;
    logic             ext_i = 1'b0;
    logic [IMM_W-1:0] imm_i = '0;
    logic [XLEN-1:0]  reg_i = '0, t8_i = '0, ra_i = '0;
    logic [XLEN-1:0]  npc_o, link_o, exc_pc_o;
    logic             link_we_o, isa16_o, dslot_o, illegal_o;

    always #2.5 clk = ~clk;

    npc_unit #(.XLEN(XLEN)) dut (.*);

    typedef struct {
        logic            chk_npc;
        logic [XLEN-1:0] npc;
        logic            link_we;
        logic [XLEN-1:0] link;
        logic            dslot;
        logic            illegal;
        logic [XLEN-1:0] exc;
        logic            mode;
        string           req;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic            m_dslot = 1'b0;
    logic            m_mode  = 1'b1;
    logic [XLEN-1:0] m_pend  = '0;
    logic [XLEN-1:0] m_jpc   = '0;

    task automatic cmp(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                if (it.chk_npc) cmp(it.req, "npc", npc_o, it.npc);
                cmp(it.req, "link_we", XLEN'(link_we_o), XLEN'(it.link_we));
                if (it.link_we) cmp(it.req, "link", link_o, it.link);
                cmp(it.req, "dslot", XLEN'(dslot_o), XLEN'(it.dslot));
                cmp(it.req, "illegal", XLEN'(illegal_o), XLEN'(it.illegal));
                cmp(it.req, "exc_pc", exc_pc_o, it.exc);
                cmp(it.req, "mode", XLEN'(isa16_o), XLEN'(it.mode));
            end
        end
    end

    function automatic logic [IMM_W-1:0] pack_idx(logic [25:0] idx);
        return {idx[20:16], idx[25:21], idx[15:0]};
    endfunction

    task automatic issue(cf_kind_e k, logic ext, logic [IMM_W-1:0] imm,
                         logic [XLEN-1:0] rv, logic [XLEN-1:0] t8,
                         logic [XLEN-1:0] ra, logic [XLEN-1:0] pc, string req);
        item_t it;
        logic [XLEN-1:0] nia, off, tgt;
        logic [25:0] idx;
        logic taken, ctl, jmp;
        int w;
        @(negedge clk);
        acc_i = 1'b1; kind_i = k; ext_i = ext; imm_i = imm;
        reg_i = rv; t8_i = t8; ra_i = ra; pc_i = pc;
        nia = pc + ((ext || k == CF_JAL || k == CF_JALX) ? 32'd4 : 32'd2);
        jmp = (k >= CF_JAL && k <= CF_JALR);
        ctl = jmp || (k >= CF_BEQZ && k <= CF_B);
        it.chk_npc = 1'b1; it.req = req; it.mode = m_mode; it.dslot = m_dslot;
        it.link_we = 1'b0; it.link = nia + 32'd2; it.illegal = 1'b0;
        it.exc = m_dslot ? m_jpc : pc;
        if (m_dslot) begin
            it.npc = {m_pend[XLEN-1:1], 1'b0};
            it.illegal = ctl;
            m_mode = m_pend[0];
            m_dslot = 1'b0;
        end else if (jmp) begin
            idx = {imm[20:16], imm[25:21], imm[15:0]};
            case (k)
                CF_JAL:  tgt = {nia[31:28], idx, 2'b00} | 32'd1;
                CF_JALX: tgt = {nia[31:28], idx, 2'b00};
                CF_JRRA: tgt = ra;
                default: tgt = rv;
            endcase
            it.npc = nia;
            it.link_we = (k == CF_JAL || k == CF_JALX || k == CF_JALR);
            m_dslot = 1'b1; m_pend = tgt; m_jpc = pc;
        end else begin
            w = ext ? 16 : (k == CF_B ? 11 : 8);
            off = 32'(imm) & ((32'd1 << w) - 1);
            if (off[w-1]) off = off | ~((32'd1 << w) - 1);
            case (k)
                CF_BEQZ:  taken = (rv == 0);
                CF_BNEZ:  taken = (rv != 0);
                CF_BTEQZ: taken = (t8 == 0);
                CF_BTNEZ: taken = (t8 != 0);
                CF_B:     taken = 1'b1;
                default:  taken = 1'b0;
            endcase
            it.npc = taken ? nia + (off << 1) : nia;
        end
        q.push_back(it);
    endtask

    task automatic idle(string req);
        item_t it;
        @(negedge clk);
        acc_i = 1'b0;
        it.chk_npc = 1'b0; it.npc = '0; it.link_we = 1'b0; it.link = '0;
        it.dslot = m_dslot; it.illegal = 1'b0; it.mode = m_mode;
        it.exc = m_dslot ? m_jpc : pc_i; it.req = req;
        q.push_back(it);
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1", "dslot", XLEN'(dslot_o), 0);
        cmp("R1", "mode", XLEN'(isa16_o), 1);
        cmp("R1", "link_we", XLEN'(link_we_o), 0);
        cmp("R1", "illegal", XLEN'(illegal_o), 0);
        rst_n = 1'b1;

        // R2 sequential
        issue(CF_NONE, 0, 0, 0, 0, 0, 32'h1000, "R2");
        issue(CF_NONE, 1, 0, 0, 0, 0, 32'h1004, "R2");
        // R3 conditions
        issue(CF_BEQZ, 0, 26'h10, 0, 0, 0, 32'h2000, "R3");
        issue(CF_BEQZ, 0, 26'h10, 5, 0, 0, 32'h2000, "R3");
        issue(CF_BNEZ, 0, 26'hF0, 5, 0, 0, 32'h2000, "R3");
        issue(CF_BNEZ, 0, 26'hF0, 0, 7, 0, 32'h2000, "R3");
        issue(CF_BTEQZ, 0, 26'h01, 9, 0, 0, 32'h2100, "R3");
        issue(CF_BTNEZ, 0, 26'h01, 9, 0, 0, 32'h2100, "R3");
        issue(CF_BTNEZ, 0, 26'h7F, 0, 3, 0, 32'h2100, "R3");
        // R4 offset widths
        issue(CF_BEQZ, 0, 26'h0380, 0, 0, 0, 32'h40000, "R4");
        issue(CF_B, 0, 26'h37FF, 0, 0, 0, 32'h40000, "R4");
        issue(CF_B, 0, 26'h0400, 0, 0, 0, 32'h40000, "R4");
        issue(CF_BEQZ, 1, 26'h3F8000, 0, 0, 0, 32'h40000, "R4");
        issue(CF_B, 1, 26'h0100, 0, 0, 0, 32'h40000, "R4");
        issue(CF_BTNEZ, 1, 26'h7FFF, 0, 1, 0, 32'h40000, "R4");
        // R5 R7 R8 R10 jal with delay slot
        issue(CF_JAL, 0, pack_idx(26'h2ABCDEF), 0, 0, 0, 32'h1234_5000, "R5");
        issue(CF_NONE, 0, 0, 0, 0, 0, 32'h1234_5004, "R8");
        issue(CF_NONE, 0, 0, 0, 0, 0, 32'h0AF3_7BBC, "R6");
        // R6 jalx switches mode, with idle cycles inside the slot (R9)
        issue(CF_JALX, 0, pack_idx(26'h0123456), 0, 0, 0, 32'hF000_0100, "R6");
        idle("R9");
        idle("R9");
        issue(CF_NONE, 0, 0, 0, 0, 0, 32'hF000_0104, "R10");
        issue(CF_NONE, 0, 0, 0, 0, 0, 32'h1000_2000, "R6");
        // R12 register jumps and mode from bit 0
        issue(CF_JR, 0, 0, 32'h0000_3001, 0, 0, 32'h1000_2002, "R12");
        issue(CF_NONE, 0, 0, 0, 0, 0, 32'h1000_2004, "R12");
        issue(CF_JALR, 0, 0, 32'h0000_5000, 0, 0, 32'h3000, "R7");
        issue(CF_NONE, 1, 0, 0, 0, 0, 32'h3002, "R8");
        issue(CF_JRRA, 0, 0, 32'h0000_7777, 0, 32'h0000_6001, 32'h5000, "R12");
        issue(CF_NONE, 0, 0, 0, 0, 0, 32'h5002, "R12");
        // R11 control transfers inside a delay slot
        issue(CF_JR, 0, 0, 32'h0000_8001, 0, 0, 32'h6000, "R11");
        issue(CF_BEQZ, 0, 26'h10, 0, 0, 0, 32'h6002, "R11");
        issue(CF_JAL, 0, pack_idx(26'h0000010), 0, 0, 0, 32'h8000, "R11");
        issue(CF_JALR, 0, 0, 32'h0000_9000, 0, 0, 32'h8004, "R11");
        issue(CF_NONE, 0, 0, 0, 0, 0, 32'h0000_0044, "R11");
        issue(CF_NONE, 0, 0, 0, 0, 0, 32'h0000_0046, "R2");
        idle("R9");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule